// File: doc/BRIEF.md
# Interrupt Redirection Message Dispatcher

This block turns numbered interrupt request lines into interrupt messages for processor-local interrupt controllers. Each line has its own entry in a redirection table. An entry holds a vector, a delivery mode, a destination-mode flag, an 8-bit destination field and a mask bit. A request arrives as a line number on a valid/ready input. The block reads that line's entry and checks it. It then sends zero, one or several messages on a valid/ready output stream.

When the destination-mode flag is clear, the destination field is a single controller ID and one message goes out. When the flag is set, the field is a bitmask. The block sends one message per set bit, walking from the lowest bit upward, and each message is addressed to that bit's index. A request is rejected with a one-cycle error pulse in two cases: its line number is beyond the table, or its entry uses a reserved delivery mode. Software loads and inspects entries through a plain write port and a read port. Every message in a burst is built from a copy of the entry taken when the burst starts, so later table writes cannot split a burst.

Top module: `irq_redirect_dispatch`

## Requirements
- R1: After reset is released, every table entry reads back as zero. `req_ready` stays low for exactly DEPTH clock cycles while the table is being cleared, and `msg_valid` and `err_o` are low.
- R2: A write through `tbl_we` stores the entry; reading its index returns it one cycle later. Entry layout: bit 20 is the mask, bits 19:12 the destination, bit 11 the destination-mode flag (1 = bitmask), bits 10:8 the delivery mode, and bits 7:0 the vector.
- R3: A request whose entry has the mask bit set emits no message and raises no error. This holds even if the mode is reserved.
- R4: For an unmasked entry with delivery mode 3 or 6, the request emits no message and raises `err_o` for exactly one cycle. The other modes (0, 1, 2, 4, 5, 7) are forwarded.
- R5: A request on a line number at or above DEPTH emits no message and raises `err_o` for exactly one cycle.
- R6: With the destination-mode flag clear, exactly one message is emitted, and its `msg_dest` equals the 8-bit destination field.
- R7: With the flag set, one message is emitted for each set destination bit, in ascending bit order, with `msg_dest` equal to that bit's index. An all-zero mask emits nothing and raises no error.
- R8: Every message carries the entry's vector, delivery mode and destination-mode flag.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid` stays high and all message fields stay unchanged.
- R10: `req_ready` is low from the cycle after a request is accepted until the last message of that request has been handed over.
- R11: A table write that lands while a burst is in progress does not change any message of that burst. The next request on that line uses the new entry.
- R12: `self_id` and `arb_id` both take the value of `cfg_id` at reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_id | input | 4 | Block ID captured at reset |
| self_id | output | 4 | Block ID |
| arb_id | output | 4 | Arbitration ID, starts equal to the block ID |
| tbl_we | input | 1 | Table write strobe |
| tbl_waddr | input | 5 | Table write index |
| tbl_wdata | input | 21 | Entry to write |
| tbl_raddr | input | 5 | Table read index |
| tbl_rdata | output | 21 | Entry read, one cycle after the index |
| req_valid | input | 1 | Interrupt request present |
| req_line | input | 5 | Requesting line number |
| req_ready | output | 1 | Block can accept a request |
| msg_valid | output | 1 | Message present |
| msg_ready | input | 1 | Downstream takes the message |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery mode |
| msg_logical | output | 1 | Message destination-mode flag |
| msg_dest | output | 8 | Target controller ID |
| err_o | output | 1 | One-cycle error pulse for a rejected request |

## Verification
The assertions check four properties on every cycle:
- a stalled message holds its value;
- `req_ready` is never high while a message is pending;
- an error pulse never coincides with a message;
- an error lasts a single cycle.

The bench scenarios cover the rest:
- the ascending order and the count of bitmask expansions;
- mask taking precedence over a reserved mode;
- out-of-range lines;
- the snapshot behaviour when a write hits a burst in flight;
- the zero-filled table after reset.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int VEC_W  = 8;
  localparam int DST_W  = 8;
  localparam int MODE_W = 3;

  typedef struct packed {
    logic              mask;
    logic [DST_W-1:0]  dest;
    logic              logical;
    logic [MODE_W-1:0] mode;
    logic [VEC_W-1:0]  vector;
  } redir_t;

  localparam int ENTRY_W = $bits(redir_t);

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_LOOK = 2'd1,
    S_SEND = 2'd2
  } disp_state_t;

  function automatic logic mode_reserved(input logic [MODE_W-1:0] m);
    return (m == 3'd3) || (m == 3'd6);
  endfunction
endpackage

// File: rtl/irqd_table.sv
module irqd_table
  import irqd_pkg::*;
#(
  parameter int DEPTH = 24,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  redir_t        wr_data,
  input  logic [AW-1:0] rda_addr,
  output redir_t        rda_data,
  input  logic [AW-1:0] rdb_addr,
  output redir_t        rdb_data,
  output logic          busy
);
  localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

  redir_t        mem [DEPTH];
  logic [AW-1:0] clr_cnt;

  // zero-fill sweep after reset keeps the array free of a reset port
  always_ff @(posedge clk) begin
    if (rst) begin
      clr_cnt <= '0;
      busy    <= 1'b1;
    end else if (busy) begin
      clr_cnt <= clr_cnt + 1'b1;
      if (clr_cnt == AW'(DEPTH - 1)) busy <= 1'b0;
    end
  end

  logic [AW-1:0] wa_idx, ra_idx, rb_idx;
  logic          wr_ok;
  assign wr_ok  = wr_en && ({1'b0, wr_addr} < LIMIT);
  assign wa_idx = busy ? clr_cnt : wr_addr;
  assign ra_idx = ({1'b0, rda_addr} < LIMIT) ? rda_addr : '0;
  assign rb_idx = ({1'b0, rdb_addr} < LIMIT) ? rdb_addr : '0;

  always_ff @(posedge clk) begin
    if (busy || wr_ok) mem[wa_idx] <= busy ? '0 : wr_data;
    rda_data <= mem[ra_idx];
    rdb_data <= mem[rb_idx];
  end
endmodule

// File: rtl/irqd_scan.sv
module irqd_scan #(
  parameter int W  = 8,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  bits,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (bits[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_redirect_dispatch.sv
module irq_redirect_dispatch
  import irqd_pkg::*;
#(
  parameter int DEPTH  = 24,
  parameter int LINE_W = $clog2(DEPTH),
  parameter int ID_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ID_W-1:0]      cfg_id,
  output logic [ID_W-1:0]      self_id,
  output logic [ID_W-1:0]      arb_id,
  input  logic                 tbl_we,
  input  logic [LINE_W-1:0]    tbl_waddr,
  input  logic [ENTRY_W-1:0]   tbl_wdata,
  input  logic [LINE_W-1:0]    tbl_raddr,
  output logic [ENTRY_W-1:0]   tbl_rdata,
  input  logic                 req_valid,
  input  logic [LINE_W-1:0]    req_line,
  output logic                 req_ready,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [VEC_W-1:0]     msg_vector,
  output logic [MODE_W-1:0]    msg_mode,
  output logic                 msg_logical,
  output logic [DST_W-1:0]     msg_dest,
  output logic                 err_o
);
  localparam int          IDX_W = $clog2(DST_W);
  localparam logic [LINE_W:0] LIMIT = (LINE_W+1)'(DEPTH);

  disp_state_t       state;
  logic [LINE_W-1:0] line_q;
  logic [DST_W-1:0]  rem_q;
  logic              busy;
  redir_t            ent, rd_a;

  irqd_table #(.DEPTH(DEPTH), .AW(LINE_W)) u_tbl (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (tbl_we),
    .wr_addr  (tbl_waddr),
    .wr_data  (redir_t'(tbl_wdata)),
    .rda_addr (tbl_raddr),
    .rda_data (rd_a),
    .rdb_addr (req_line),
    .rdb_data (ent),
    .busy     (busy)
  );
  assign tbl_rdata = rd_a;

  logic             hit_e, hit_r;
  logic [IDX_W-1:0] idx_e, idx_r;

  irqd_scan #(.W(DST_W)) u_scan_ent (.bits(ent.dest), .hit(hit_e), .idx(idx_e));
  irqd_scan #(.W(DST_W)) u_scan_rem (.bits(rem_q),    .hit(hit_r), .idx(idx_r));

  assign req_ready = (state == S_IDLE) && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      line_q      <= '0;
      rem_q       <= '0;
      msg_valid   <= 1'b0;
      msg_vector  <= '0;
      msg_mode    <= '0;
      msg_logical <= 1'b0;
      msg_dest    <= '0;
      err_o       <= 1'b0;
      self_id     <= cfg_id;
      arb_id      <= cfg_id;
    end else begin
      err_o <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (req_valid && req_ready) begin
            line_q <= req_line;
            state  <= S_LOOK;
          end
        end
        S_LOOK: begin
          state       <= S_IDLE;
          msg_vector  <= ent.vector;
          msg_mode    <= ent.mode;
          msg_logical <= ent.logical;
          if ({1'b0, line_q} >= LIMIT) begin
            err_o <= 1'b1;
          end else if (ent.mask) begin
            err_o <= 1'b0;
          end else if (mode_reserved(ent.mode)) begin
            err_o <= 1'b1;
          end else if (!ent.logical) begin
            msg_dest  <= ent.dest;
            rem_q     <= '0;
            msg_valid <= 1'b1;
            state     <= S_SEND;
          end else if (hit_e) begin
            msg_dest  <= DST_W'(idx_e);
            rem_q     <= ent.dest & ~(DST_W'(1) << idx_e);
            msg_valid <= 1'b1;
            state     <= S_SEND;
          end
        end
        S_SEND: begin
          if (msg_ready) begin
            if (hit_r) begin
              msg_dest <= DST_W'(idx_r);
              rem_q    <= rem_q & ~(DST_W'(1) << idx_r);
            end else begin
              msg_valid <= 1'b0;
              state     <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_dest) && $stable(msg_vector)
                                && $stable(msg_mode) && $stable(msg_logical));

  assert_ready_low_R10: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> !req_ready);

  assert_err_nomsg_R4: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !msg_valid);

  assert_err_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o);
endmodule

// File: tb/sim_irq_redirect_dispatch.sv
module sim_irq_redirect_dispatch;
  localparam int DEPTH = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cfg_id = 4'hB;
  logic [3:0]  self_id, arb_id;
  logic        tbl_we = 1'b0;
  logic [4:0]  tbl_waddr = '0, tbl_raddr = '0, req_line = '0;
  logic [20:0] tbl_wdata = '0, tbl_rdata;
  logic        req_valid = 1'b0, req_ready;
  logic        msg_valid, msg_ready = 1'b1, msg_logical, err_o;
  logic [7:0]  msg_vector, msg_dest;
  logic [2:0]  msg_mode;

  int n_cmp = 0;
  int n_bad = 0;

  always #5ns clk = ~clk;

  irq_redirect_dispatch #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .cfg_id(cfg_id), .self_id(self_id), .arb_id(arb_id),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .tbl_raddr(tbl_raddr), .tbl_rdata(tbl_rdata),
    .req_valid(req_valid), .req_line(req_line), .req_ready(req_ready),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_mode(msg_mode), .msg_logical(msg_logical), .msg_dest(msg_dest), .err_o(err_o)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [20:0] d);
    tbl_we = 1'b1; tbl_waddr = 5'(a); tbl_wdata = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [20:0] d);
    tbl_raddr = 5'(a);
    @(negedge clk);
    d = tbl_rdata;
  endtask

  function automatic logic [20:0] mk(input int l, input int p);
    logic [7:0] v, d;
    logic [2:0] m;
    logic lg, mk_b;
    v = 8'(l * 11 + 5 + p * 100);
    m = 3'(l + p * 3);
    lg = 1'(l) ^ 1'(p);
    case (l % 6)
      0: d = 8'h00;
      1: d = 8'hFF;
      2: d = 8'h80;
      3: d = 8'h01;
      default: d = 8'(l * 37 + p * 53 + 1);
    endcase
    mk_b = (l % 9 == 7);
    return {mk_b, d, lg, m, v};
  endfunction

  task automatic run_req(input int line, input logic [20:0] e, input bit stall,
                         input bit mid_wr, input logic [20:0] newe);
    logic [7:0] exp_d [8];
    int  exp_n, got, errs;
    bit  exp_err, prev_hold, done, wrote;
    logic [7:0] sv_d, sv_v;
    logic [2:0] sv_m;
    logic sv_l;
    string tag;
    exp_n = 0; exp_err = 0;
    if (line >= DEPTH) begin
      exp_err = 1; tag = "R5";
    end else if (e[20]) begin
      tag = "R3";
    end else if (e[10:8] == 3'd3 || e[10:8] == 3'd6) begin
      exp_err = 1; tag = "R4";
    end else if (!e[11]) begin
      exp_d[0] = e[19:12]; exp_n = 1; tag = "R6";
    end else begin
      tag = "R7";
      for (int b = 0; b < 8; b++) if (e[12 + b]) begin exp_d[exp_n] = 8'(b); exp_n++; end
    end
    if (mid_wr) tag = "R11";
    req_valid = 1'b1; req_line = 5'(line);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10", "ready after accept", 32'(req_ready), 0);
    got = 0; errs = 0; prev_hold = 0; done = 0; wrote = 0;
    for (int c = 0; c < 80 && !done; c++) begin
      tbl_we = 1'b0;
      if (err_o) errs++;
      if (prev_hold) begin
        check("R9", "held dest", 32'(msg_dest), 32'(sv_d));
        check("R9", "held vector", 32'(msg_vector), 32'(sv_v));
        check("R9", "held valid", 32'(msg_valid), 1);
      end
      msg_ready = stall ? ((c % 3) != 1) : 1'b1;
      if (msg_valid) begin
        check("R10", "ready during burst", 32'(req_ready), 0);
        if (msg_ready) begin
          if (got < exp_n) check(tag, "dest", 32'(msg_dest), 32'(exp_d[got]));
          check("R8", "vector", 32'(msg_vector), 32'(e[7:0]));
          check("R8", "mode", 32'(msg_mode), 32'(e[10:8]));
          check("R8", "flag", 32'(msg_logical), 32'(e[11]));
          got++;
        end
      end
      prev_hold = msg_valid && !msg_ready;
      sv_d = msg_dest; sv_v = msg_vector; sv_m = msg_mode; sv_l = msg_logical;
      if (!msg_valid && req_ready) done = 1;
      if (mid_wr && !wrote && got == 2 && msg_valid) begin
        tbl_we = 1'b1; tbl_waddr = 5'(line); tbl_wdata = newe; wrote = 1;
      end
      if (!done) @(negedge clk);
    end
    tbl_we = 1'b0;
    msg_ready = 1'b1;
    check(tag, "message count", 32'(got), 32'(exp_n));
    check(tag, "error cycles", 32'(errs), 32'(exp_err));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [20:0] d;
    int wait_n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    wait_n = 0;
    check("R1", "msg_valid idle", 32'(msg_valid), 0);
    check("R1", "err idle", 32'(err_o), 0);
    while (!req_ready && wait_n < 100) begin wait_n++; @(negedge clk); end
    check("R1", "clear cycles", 32'(wait_n), DEPTH);
    check("R12", "self_id", 32'(self_id), 32'hB);
    check("R12", "arb_id", 32'(arb_id), 32'hB);
    for (int a = 0; a < DEPTH; a++) begin
      rd(a, d);
      check("R1", "entry zero", 32'(d), 0);
    end
    for (int p = 0; p < 2; p++) begin
      for (int l = 0; l < DEPTH; l++) wr(l, mk(l, p));
      for (int l = 0; l < DEPTH; l++) begin
        rd(l, d);
        check("R2", "readback", 32'(d), 32'(mk(l, p)));
      end
      for (int l = 0; l < DEPTH; l++) run_req(l, mk(l, p), 1'(l >> 1), 1'b0, '0);
    end
    for (int l = DEPTH; l < 32; l++) run_req(l, '0, 1'b0, 1'b0, '0);
    // R11: rewrite line 3 while its bitmask burst is stalled
    wr(3, {1'b0, 8'hFF, 1'b1, 3'd0, 8'h44});
    run_req(3, {1'b0, 8'hFF, 1'b1, 3'd0, 8'h44}, 1'b1, 1'b1,
            {1'b0, 8'h24, 1'b1, 3'd4, 8'h99});
    rd(3, d);
    check("R11", "new entry stored", 32'(d), 32'({1'b0, 8'h24, 1'b1, 3'd4, 8'h99}));
    run_req(3, {1'b0, 8'h24, 1'b1, 3'd4, 8'h99}, 1'b0, 1'b0, '0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule